// File: doc/BRIEF.md
# Randomized Test Packet Source

This block produces a steady stream of test packets on a 128-bit word interface that feeds a transmit buffer. It runs on the buffer's internal data clock. Every packet opens with one header word. The header holds a constant marker, a packet type, a running serial number and the packet length in bytes. Payload words follow the header, and they carry a byte pattern that a checker downstream can predict. Each word is tagged with a port number. Words leave in the order they are built, because the buffer behind this block has no scheduler of its own.

The packet length comes from a 16-bit configuration input, or from a 32-bit LFSR when random size is selected. The idle time between packets is normally fixed. It can also be drawn from the LFSR. Two run-time inputs corrupt the header marker or the payload words on purpose, so that error counters in the receive path can be exercised. The sink's space-available flag gates every word. A word that is held back waits unchanged until the flag returns.

Top module: `pkt_src_top`

## Requirements
- R1: After reset no word is issued until `genEn` is high, the first packet carries serial number 0, and `txErr` is low on every cycle.
- R2: `txEna` is high only on cycles where `spaceOk` is high. `txSop`, `txEop` and a non-zero `txEmpty` appear only together with `txEna`. A packet opens with `txSop` and closes with `txEop` before the next `txSop`. A stalled word is held until it is taken.
- R3: The header word (the one with `txSop`) has the marker 16'hC3A5 in bits [127:112], the type 8'h5A in [111:104], the serial number in [103:88], the total packet length in bytes (header included) in [87:72], and zeros in [71:0].
- R4: The serial number grows by one for every packet, modulo 2^16.
- R5: With `randSize` low the length field equals `sizeCfg`, except that values below 16 are raised to 16. The packet spans ceil(length/16) words, header included.
- R6: `txEop` is high on the last word only. There, `txEmpty` = (16 - length mod 16) mod 16. On every other word `txEmpty` is 0.
- R7: With `randSize` high each length is drawn from the LFSR and lies in 16..255, and successive lengths vary.
- R8: With `randGap` low and `spaceOk` held high, exactly one cycle without `txEna` separates an end-of-packet word from the next header.
- R9: With `randGap` high the number of idle cycles between packets lies in 1..16 and varies.
- R10: Payload word w (the header is word 0) carries in byte lane i the value {w mod 16, i} as two 4-bit halves. Lane 0 is bits [127:120] and lane 15 is bits [7:0]. The pattern is driven on all lanes, including empty ones.
- R11: A payload word issued while `payErrIns` is high has every bit inverted. A header issued while `hdrErrIns` is high carries the inverted marker 16'h3C5A, and all its other fields stay intact.
- R12: `txPort` equals `portSel` as sampled when the packet's length is chosen, and it holds for every word of the packet.
- R13: When `genEn` falls, the packet under way finishes normally and no further packet starts while `genEn` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock of the sink buffer |
| rstN | input | 1 | Active-low synchronous reset |
| genEn | input | 1 | Permits new packets to start |
| spaceOk | input | 1 | Sink can accept a word this cycle |
| sizeCfg | input | 16 | Packet length in bytes when random size is off |
| randSize | input | 1 | Draw packet lengths from the LFSR |
| randGap | input | 1 | Draw inter-packet gaps from the LFSR |
| portSel | input | 4 | Port tag for the next packet |
| hdrErrIns | input | 1 | Corrupt the marker of the header being issued |
| payErrIns | input | 1 | Corrupt the payload words being issued |
| txEna | output | 1 | Word valid and taken this cycle |
| txData | output | 128 | Word data, lane 0 in the top byte |
| txSop | output | 1 | Header word of a packet |
| txEop | output | 1 | Last word of a packet |
| txEmpty | output | 4 | Unused byte lanes on the last word |
| txErr | output | 1 | Word error flag, held low |
| txPort | output | 4 | Port tag of the word |

## Verification
The hardest situation to reach from the ports is a stall that hits a header or a final word just as the gap logic is about to re-arm. Only then do the end-of-packet, empty-count and serial-number paths interact with `spaceOk`. The stimulus gets there by running random lengths and random gaps while `spaceOk` follows an irregular pattern of low cycles, so that stalls fall on headers, middle words and last words alike. A separate sweep of every fixed length from 0 to 80 bytes covers each empty-count value and the single-word packet, and one 65535-byte packet covers the top of the length range.

// File: rtl/pkt_src_pkg.sv
package pkt_src_pkg;

  localparam int LEN_W = 16;
  localparam int SEQ_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SIZE,
    ST_HDR,
    ST_PAY,
    ST_GAP
  } genState_t;

  typedef struct packed {
    logic pickLen;
    logic hdrPhase;
    logic takeHdr;
    logic takePay;
  } dpStrobe_t;

endpackage

// File: rtl/pkt_src_ctrl.sv
module pkt_src_ctrl
  import pkt_src_pkg::*;
#(
  parameter int GAP_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             genEn,
  input  logic             spaceOk,
  input  logic             randGap,
  input  logic             lastWord,
  input  logic [GAP_W-1:0] rndGap,
  output dpStrobe_t        strb,
  output logic             wordValid
);

  genState_t        state, nextState;
  logic [GAP_W-1:0] gapCnt;
  logic             endPkt;
  logic             goGap;
  genState_t        restState;

  always_comb begin
    strb          = '0;
    strb.pickLen  = (state == ST_SIZE);
    strb.hdrPhase = (state == ST_HDR);
    strb.takeHdr  = (state == ST_HDR) && spaceOk;
    strb.takePay  = (state == ST_PAY) && spaceOk;
    wordValid     = strb.takeHdr || strb.takePay;
    endPkt        = wordValid && lastWord;
    goGap         = randGap && (rndGap != '0);
    restState     = genEn ? ST_SIZE : ST_IDLE;
  end

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE: if (genEn) nextState = ST_SIZE;
      ST_SIZE: nextState = ST_HDR;
      ST_HDR: begin
        if (endPkt)            nextState = goGap ? ST_GAP : restState;
        else if (strb.takeHdr) nextState = ST_PAY;
      end
      ST_PAY: if (endPkt) nextState = goGap ? ST_GAP : restState;
      ST_GAP: if (gapCnt == GAP_W'(1)) nextState = restState;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      gapCnt <= '0;
    end else begin
      state <= nextState;
      if (endPkt && goGap)    gapCnt <= rndGap;
      else if (state == ST_GAP) gapCnt <= gapCnt - 1'b1;
    end
  end

endmodule

// File: rtl/pkt_src_dp.sv
module pkt_src_dp
  import pkt_src_pkg::*;
#(
  parameter int          DATA_W     = 128,
  parameter int          PORT_W     = 4,
  parameter int          RAND_LEN_W = 8,
  parameter int          GAP_W      = 4,
  parameter logic [15:0] MARKER     = 16'hC3A5,
  parameter logic [7:0]  PKT_TYPE   = 8'h5A,
  parameter logic [31:0] LFSR_SEED  = 32'h1D2C_3B4A
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  dpStrobe_t                          strb,
  input  logic                               wordValid,
  input  logic                               randSize,
  input  logic [LEN_W-1:0]                   sizeCfg,
  input  logic [PORT_W-1:0]                  portSel,
  input  logic                               hdrErrIns,
  input  logic                               payErrIns,
  output logic                               lastWord,
  output logic [GAP_W-1:0]                   rndGap,
  output logic [DATA_W-1:0]                  txData,
  output logic                               txSop,
  output logic                               txEop,
  output logic [$clog2(DATA_W/8)-1:0]        txEmpty,
  output logic                               txErr,
  output logic [PORT_W-1:0]                  txPort
);

  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int PAT_W  = 8 - LANE_W;
  localparam int HDR_W  = 16 + 8 + SEQ_W + LEN_W;
  localparam logic [LEN_W-1:0] MIN_LEN   = LEN_W'(LANES);
  localparam logic [LEN_W-1:0] RAND_MASK = LEN_W'((1 << RAND_LEN_W) - 1);

  logic [31:0]        lfsr;
  logic [15:0]        rnd16;
  logic [LEN_W-1:0]   rawLen, lenPick, lenReg, remBytes;
  logic [SEQ_W-1:0]   serial;
  logic [PAT_W-1:0]   wordIdx;
  logic [PORT_W-1:0]  portReg;
  logic [DATA_W-1:0]  payWord, hdrWord;

  always_comb begin
    rnd16   = lfsr[31:16] ^ lfsr[15:0];
    rawLen  = randSize ? (LEN_W'(rnd16) & RAND_MASK) : sizeCfg;
    lenPick = (rawLen < MIN_LEN) ? MIN_LEN : rawLen;
    rndGap  = rnd16[15 -: GAP_W];
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [LANE_W-1:0] LID = LANE_W'(i);
    assign payWord[DATA_W-1-8*i -: 8] = {wordIdx, LID};
  end

  assign hdrWord = {MARKER ^ {16{hdrErrIns}}, PKT_TYPE, serial, lenReg,
                    {(DATA_W-HDR_W){1'b0}}};

  always_comb begin
    lastWord = (remBytes <= MIN_LEN);
    txSop    = strb.takeHdr;
    txEop    = wordValid && lastWord;
    txEmpty  = txEop ? LANE_W'(MIN_LEN - remBytes) : '0;
    txErr    = 1'b0;
    txPort   = wordValid ? portReg : '0;
    if (!wordValid)        txData = '0;
    else if (strb.hdrPhase) txData = hdrWord;
    else                   txData = payWord ^ {DATA_W{payErrIns}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsr     <= LFSR_SEED;
      lenReg   <= '0;
      remBytes <= '0;
      serial   <= '0;
      wordIdx  <= '0;
      portReg  <= '0;
    end else begin
      lfsr <= {1'b0, lfsr[31:1]} ^ (lfsr[0] ? 32'h8020_0003 : 32'h0);
      if (strb.pickLen) begin
        lenReg   <= lenPick;
        remBytes <= lenPick;
        wordIdx  <= PAT_W'(1);
        portReg  <= portSel;
      end
      if (strb.takeHdr) begin
        serial   <= serial + 1'b1;
        remBytes <= remBytes - MIN_LEN;
      end
      if (strb.takePay) begin
        remBytes <= remBytes - MIN_LEN;
        wordIdx  <= wordIdx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pkt_src_top.sv
module pkt_src_top
  import pkt_src_pkg::*;
#(
  parameter int          DATA_W     = 128,
  parameter int          PORT_W     = 4,
  parameter int          RAND_LEN_W = 8,
  parameter int          GAP_W      = 4,
  parameter logic [15:0] MARKER     = 16'hC3A5,
  parameter logic [7:0]  PKT_TYPE   = 8'h5A,
  parameter logic [31:0] LFSR_SEED  = 32'h1D2C_3B4A
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        genEn,
  input  logic                        spaceOk,
  input  logic [15:0]                 sizeCfg,
  input  logic                        randSize,
  input  logic                        randGap,
  input  logic [PORT_W-1:0]           portSel,
  input  logic                        hdrErrIns,
  input  logic                        payErrIns,
  output logic                        txEna,
  output logic [DATA_W-1:0]           txData,
  output logic                        txSop,
  output logic                        txEop,
  output logic [$clog2(DATA_W/8)-1:0] txEmpty,
  output logic                        txErr,
  output logic [PORT_W-1:0]           txPort
);

  dpStrobe_t        strb;
  logic             wordValid;
  logic             lastWord;
  logic [GAP_W-1:0] rndGap;

  pkt_src_ctrl #(.GAP_W(GAP_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .genEn     (genEn),
    .spaceOk   (spaceOk),
    .randGap   (randGap),
    .lastWord  (lastWord),
    .rndGap    (rndGap),
    .strb      (strb),
    .wordValid (wordValid)
  );

  pkt_src_dp #(
    .DATA_W     (DATA_W),
    .PORT_W     (PORT_W),
    .RAND_LEN_W (RAND_LEN_W),
    .GAP_W      (GAP_W),
    .MARKER     (MARKER),
    .PKT_TYPE   (PKT_TYPE),
    .LFSR_SEED  (LFSR_SEED)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wordValid (wordValid),
    .randSize  (randSize),
    .sizeCfg   (sizeCfg),
    .portSel   (portSel),
    .hdrErrIns (hdrErrIns),
    .payErrIns (payErrIns),
    .lastWord  (lastWord),
    .rndGap    (rndGap),
    .txData    (txData),
    .txSop     (txSop),
    .txEop     (txEop),
    .txEmpty   (txEmpty),
    .txErr     (txErr),
    .txPort    (txPort)
  );

  assign txEna = wordValid;

endmodule

// File: rtl/pkt_src_chk.sv
module pkt_src_chk #(
  parameter int DATA_W = 128,
  parameter int PORT_W = 4
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        spaceOk,
  input logic                        txEna,
  input logic                        txSop,
  input logic                        txEop,
  input logic [$clog2(DATA_W/8)-1:0] txEmpty,
  input logic [PORT_W-1:0]           txPort,
  input logic [15:0]                 hdrSeq,
  input logic [15:0]                 hdrLen
);

  logic              chkInPkt;
  logic              chkSeen;
  logic [15:0]       chkSeq;
  logic [PORT_W-1:0] chkPort;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chkInPkt <= 1'b0;
      chkSeen  <= 1'b0;
      chkSeq   <= '0;
      chkPort  <= '0;
    end else if (txEna) begin
      if (txSop) begin
        chkSeq   <= hdrSeq;
        chkSeen  <= 1'b1;
        chkPort  <= txPort;
        chkInPkt <= !txEop;
      end else if (txEop) begin
        chkInPkt <= 1'b0;
      end
    end
  end

  AST_ENA_NEEDS_SPACE: assert property (@(posedge clk) disable iff (!rstN) txEna |-> spaceOk); // R2
  AST_FLAGS_NEED_ENA: assert property (@(posedge clk) disable iff (!rstN) (txSop || txEop) |-> txEna); // R2
  AST_SOP_OPENS: assert property (@(posedge clk) disable iff (!rstN) (txEna && !chkInPkt) |-> txSop); // R2
  AST_NO_NESTED_SOP: assert property (@(posedge clk) disable iff (!rstN) txSop |-> !chkInPkt); // R2
  AST_FIRST_SEQ: assert property (@(posedge clk) disable iff (!rstN) (txSop && !chkSeen) |-> (hdrSeq == 16'd0)); // R1
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rstN) (txSop && chkSeen) |-> (hdrSeq == chkSeq + 16'd1)); // R4
  AST_LEN_FLOOR: assert property (@(posedge clk) disable iff (!rstN) txSop |-> (hdrLen >= 16'(DATA_W/8))); // R5
  AST_EMPTY_MID: assert property (@(posedge clk) disable iff (!rstN) (txEna && !txEop) |-> (txEmpty == '0)); // R6
  AST_PORT_HOLD: assert property (@(posedge clk) disable iff (!rstN) (txEna && !txSop) |-> (txPort == chkPort)); // R12

endmodule

bind pkt_src_top pkt_src_chk #(.DATA_W(DATA_W), .PORT_W(PORT_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .spaceOk (spaceOk),
  .txEna   (txEna),
  .txSop   (txSop),
  .txEop   (txEop),
  .txEmpty (txEmpty),
  .txPort  (txPort),
  .hdrSeq  (txData[DATA_W-25 -: 16]),
  .hdrLen  (txData[DATA_W-41 -: 16])
);

// File: tb/sim_pkt_src_top.sv
`timescale 1ns/1ps
module sim_pkt_src_top;

  logic         clk = 1'b0;
  logic         rstN;
  logic         genEn;
  logic         spaceOk;
  logic [15:0]  sizeCfg;
  logic         randSize;
  logic         randGap;
  logic [3:0]   portSel;
  logic         hdrErrIns;
  logic         payErrIns;
  logic         txEna;
  logic [127:0] txData;
  logic         txSop;
  logic         txEop;
  logic [3:0]   txEmpty;
  logic         txErr;
  logic [3:0]   txPort;

  pkt_src_top u0 (
    .clk(clk), .rstN(rstN), .genEn(genEn), .spaceOk(spaceOk), .sizeCfg(sizeCfg),
    .randSize(randSize), .randGap(randGap), .portSel(portSel),
    .hdrErrIns(hdrErrIns), .payErrIns(payErrIns), .txEna(txEna), .txData(txData),
    .txSop(txSop), .txEop(txEop), .txEmpty(txEmpty), .txErr(txErr), .txPort(txPort)
  );

  always #4 clk = ~clk;

  int nChk = 0;
  int nErr = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // spaceOk driver
  bit stallMode = 0;
  int drvCyc = 0;
  always @(posedge clk) begin
    #1;
    drvCyc++;
    spaceOk = stallMode ? ((drvCyc % 3 != 0) && (drvCyc % 7 != 2)) : 1'b1;
  end

  // monitor state
  int cyc = 0;
  bit inPkt = 0;
  int curLen = 0, wordsExp = 0, wIdx = 0;
  logic [15:0] expSer = 16'd0;
  int lastEopCyc = 0;
  bit gapValid = 0, stallSince = 0;
  int sopCnt = 0, eopCnt = 0, stopAt = 0;
  bit expectQuiet = 0;
  int quietEna = 0;
  int minLen = 0, maxLen = 0, maxGap = 0;

  always @(negedge clk) begin
    if (rstN) begin
      cyc++;
      if (txEna) begin
        if (expectQuiet) quietEna++;
        chk(spaceOk, "R2 ena without space", 128'(spaceOk), 128'(1));
        chk(!txErr, "R1 err flag", 128'(txErr), 128'(0));
        chk(txPort == portSel, "R12 port", 128'(txPort), 128'(portSel));
        if (txSop) begin
          logic [15:0]  mk;
          logic [127:0] expHdr;
          int idle;
          chk(!inPkt, "R2 sop inside packet", 128'(inPkt), 128'(0));
          curLen = int'(txData[87:72]);
          mk = hdrErrIns ? 16'h3C5A : 16'hC3A5;
          expHdr = {mk, 8'h5A, expSer, txData[87:72], 72'h0};
          chk(txData == expHdr, (sopCnt == 0) ? "R1 R3 R4 header" : "R3 R4 R11 header",
              txData, expHdr);
          if (randSize) begin
            chk(curLen >= 16 && curLen <= 255, "R7 random length", 128'(curLen), 128'(255));
            if (curLen < minLen) minLen = curLen;
            if (curLen > maxLen) maxLen = curLen;
          end else begin
            int e;
            e = (sizeCfg < 16) ? 16 : int'(sizeCfg);
            chk(curLen == e, "R5 fixed length", 128'(curLen), 128'(e));
          end
          idle = cyc - lastEopCyc - 1;
          if (gapValid) begin
            if (stallSince)
              chk(idle >= 1, "R8 R9 gap with stalls", 128'(idle), 128'(1));
            else if (randGap) begin
              chk(idle >= 1 && idle <= 16, "R9 random gap", 128'(idle), 128'(16));
              if (idle > maxGap) maxGap = idle;
            end else
              chk(idle == 1, "R8 fixed gap", 128'(idle), 128'(1));
          end
          wordsExp = (curLen + 15) / 16;
          wIdx = 0;
          expSer = expSer + 16'd1;
          sopCnt++;
          inPkt = 1;
          if (sopCnt == stopAt) genEn = 1'b0;
        end else begin
          logic [127:0] expPay;
          chk(inPkt, "R2 word outside packet", 128'(inPkt), 128'(1));
          for (int i = 0; i < 16; i++)
            expPay[127-8*i -: 8] = {4'(wIdx % 16), 4'(i)};
          if (payErrIns) expPay = ~expPay;
          chk(txData == expPay, payErrIns ? "R11 corrupted payload" : "R10 payload",
              txData, expPay);
        end
        chk(txEop == (wIdx == wordsExp - 1), "R6 eop position", 128'(txEop),
            128'(wIdx == wordsExp - 1));
        if (txEop) begin
          int e;
          e = (16 - (curLen % 16)) % 16;
          chk(txEmpty == 4'(e), "R6 empty count", 128'(txEmpty), 128'(e));
          inPkt = 0;
          lastEopCyc = cyc;
          gapValid = 1;
          stallSince = 0;
          eopCnt++;
        end else begin
          chk(txEmpty == 0, "R6 empty mid packet", 128'(txEmpty), 128'(0));
        end
        wIdx++;
      end else begin
        if (!spaceOk) stallSince = 1;
        if (txSop || txEop)
          chk(0, "R2 flag without ena", 128'({txSop, txEop}), 128'(0));
      end
    end
  end

  task automatic runPhase(input int n);
    gapValid = 0;
    stopAt = sopCnt + n;
    @(posedge clk); #2;
    genEn = 1'b1;
    while (eopCnt < stopAt) @(posedge clk);
    #2;
    expectQuiet = 1;
    quietEna = 0;
    repeat (40) @(posedge clk);
    expectQuiet = 0;
    chk(quietEna == 0, "R13 no packet after genEn low", 128'(quietEna), 128'(0));
  endtask

  initial begin
    #(8 * 190000);
    if (!finished) begin
      nErr++;
      nChk++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nErr, nChk);
      $finish;
    end
  end

  initial begin
    rstN = 0; genEn = 0; spaceOk = 1; sizeCfg = 16'd64; randSize = 0; randGap = 0;
    portSel = 4'd3; hdrErrIns = 0; payErrIns = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!txEna && !txSop && !txEop, "R1 reset quiet", 128'(txEna), 128'(0));
    @(posedge clk); #2;
    rstN = 1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(!txEna, "R1 idle without genEn", 128'(txEna), 128'(0));
    end

    runPhase(4);

    // sweep every small fixed length
    for (int L = 0; L <= 80; L++) begin
      sizeCfg = 16'(L);
      portSel = 4'(L % 16);
      runPhase(2);
    end
    sizeCfg = 16'd1000; runPhase(2);
    sizeCfg = 16'd65535; runPhase(1);

    // random lengths
    randSize = 1; minLen = 1 << 20; maxLen = 0; portSel = 4'd9;
    runPhase(30);
    chk(maxLen > minLen, "R7 lengths vary", 128'(maxLen), 128'(minLen));

    // random gaps
    randSize = 0; randGap = 1; sizeCfg = 16'd40; maxGap = 0;
    runPhase(30);
    chk(maxGap > 1, "R9 gaps vary", 128'(maxGap), 128'(2));

    // stalls with random length and gap
    stallMode = 1; randSize = 1; portSel = 4'd14;
    runPhase(20);
    randSize = 0; randGap = 0; sizeCfg = 16'd100;
    runPhase(5);
    stallMode = 0;

    // error injection
    payErrIns = 1; sizeCfg = 16'd80; runPhase(3);
    payErrIns = 0; hdrErrIns = 1; runPhase(3);
    hdrErrIns = 0; sizeCfg = 16'd33; runPhase(2);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

endmodule